// File: doc/BRIEF.md
# Divide-by-Three Processor Clock Generator

This block derives a processor clock and a peripheral clock from a fast reference. The reference is either a crystal-oscillator input or an external frequency input, picked by a static select pin. The processor clock is the reference divided by three. It is high for one reference period and low for two, giving a one-third duty cycle. The peripheral clock toggles on every processor-clock falling edge, so it runs at half the processor-clock rate with a 50 % duty cycle. A buffered copy of the selected reference is also driven out.

The reference inputs are oversampled by a faster system clock. Each one passes through a synchronizer, and the divider advances on each detected falling edge of the selected reference. A phase-sync input is captured on every rising edge of the external frequency input. While the captured value is high, the divider and the peripheral toggle are held at their start state. Several generators that share the external input and the sync line therefore leave the hold in the same phase. In either source mode, the external input must keep toggling for the sync input to be seen.

Top module: `clkdiv3_gen`

## Requirements
- R1: While rst_ni is low, cpu_clk_o and per_clk_o are 0.
- R2: ext_sel_i = 0 selects xtal_i as the reference and ext_sel_i = 1 selects ext_ref_i; the unselected input has no effect on the output period.
- R3: The cpu_clk_o period equals three periods of the selected reference.
- R4: cpu_clk_o is high for exactly one reference period and low for two.
- R5: cpu_clk_o changes only as a result of a reference falling edge or the sync hold, SYNC_STAGES+1 system cycles after the reference input falls.
- R6: per_clk_o toggles on each cpu_clk_o falling edge; its period is two cpu_clk_o periods and its high phase lasts one cpu_clk_o period.
- R7: phase_sync_i is sampled on each ext_ref_i rising edge; while the sampled value is 1, cpu_clk_o and per_clk_o stay 0.
- R8: After a rising edge of ext_ref_i samples phase_sync_i = 0, cpu_clk_o first rises on the second following falling edge of the selected reference.
- R9: A phase_sync_i pulse that is not present at any ext_ref_i rising edge has no effect on cpu_clk_o.
- R10: ref_buf_o equals xtal_i when ext_sel_i = 0 and ext_ref_i when ext_sel_i = 1, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xtal_i | input | 1 | Crystal-oscillator reference |
| ext_ref_i | input | 1 | External frequency reference |
| ext_sel_i | input | 1 | Reference select: 0 crystal, 1 external (static) |
| phase_sync_i | input | 1 | Phase-sync request, sampled on ext_ref_i rising edges |
| cpu_clk_o | output | 1 | Reference divided by three, one-third high |
| per_clk_o | output | 1 | cpu_clk_o divided by two |
| ref_buf_o | output | 1 | Buffered selected reference |

## Verification
If the divide counter holds a wrong count, the high phase of cpu_clk_o moves to a different reference period. If the counter reaches an illegal count, one cpu_clk_o period stretches past three reference periods. Either fault shows within one cpu_clk_o period, about six reference half-periods. A stuck or mis-phased peripheral toggle shows at the next cpu_clk_o falling edge, as a per_clk_o change that is missing or misplaced. A hold register that captures at the wrong moment either keeps both clocks low across a full cpu_clk_o period or moves the first rising edge after release away from the second reference fall.

// File: rtl/clkdiv3_pkg.sv
package clkdiv3_pkg;
  typedef enum logic {
    SRC_XTAL = 1'b0,
    SRC_EXT  = 1'b1
  } ref_src_e;

  typedef struct packed {
    logic phase_sync;
    logic ext_ref;
    logic xtal;
  } ref_bus_t;
endpackage

// File: rtl/clkdiv3_sync.sv
module clkdiv3_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clkdiv3_front.sv
module clkdiv3_front
  import clkdiv3_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ref_bus_t raw_i,
  input  ref_src_e src_i,
  output logic     ref_fall_o,
  output logic     hold_o
);
  ref_bus_t syn;
  logic     ref_now, ref_q, ext_q, ext_rise, hold_q;

  clkdiv3_sync #(.STAGES(SYNC_STAGES), .W($bits(ref_bus_t))) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_i),
    .q_o    (syn)
  );

  assign ref_now  = (src_i == SRC_EXT) ? syn.ext_ref : syn.xtal;
  assign ext_rise = syn.ext_ref & ~ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      ext_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      ref_q <= ref_now;
      ext_q <= syn.ext_ref;
      if (ext_rise) hold_q <= syn.phase_sync;
    end
  end

  assign ref_fall_o = ref_q & ~ref_now;
  assign hold_o     = hold_q;
endmodule

// File: rtl/clkdiv3_divn.sv
module clkdiv3_divn #(
  parameter int unsigned DIV_N = 3,
  parameter int unsigned CNT_W = (DIV_N > 1) ? $clog2(DIV_N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_fall_i,
  input  logic             hold_i,
  output logic             div_clk_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_N - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (hold_i)     cnt_q <= '0;
    else if (ref_fall_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
  end

  // high only in the last count: one reference period out of DIV_N
  assign div_clk_o = (cnt_q == LAST);
  assign wrap_o    = ref_fall_i & ~hold_i & (cnt_q == LAST);
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/clkdiv3_tgl.sv
module clkdiv3_tgl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic step_i,
  output logic tgl_o
);
  logic tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tgl_q <= 1'b0;
    else if (hold_i) tgl_q <= 1'b0;
    else if (step_i) tgl_q <= ~tgl_q;
  end

  assign tgl_o = tgl_q;
endmodule

// File: rtl/clkdiv3_gen.sv
module clkdiv3_gen
  import clkdiv3_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_N       = 3,
  localparam int unsigned CNT_W      = (DIV_N > 1) ? $clog2(DIV_N) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xtal_i,
  input  logic ext_ref_i,
  input  logic ext_sel_i,
  input  logic phase_sync_i,
  output logic cpu_clk_o,
  output logic per_clk_o,
  output logic ref_buf_o
);
  ref_src_e         src;
  ref_bus_t         raw;
  logic             ref_fall, hold_q, wrap;
  logic [CNT_W-1:0] div_cnt;

  assign src = ref_src_e'(ext_sel_i);
  assign raw = '{phase_sync: phase_sync_i, ext_ref: ext_ref_i, xtal: xtal_i};

  assign ref_buf_o = (src == SRC_EXT) ? ext_ref_i : xtal_i;

  clkdiv3_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .raw_i      (raw),
    .src_i      (src),
    .ref_fall_o (ref_fall),
    .hold_o     (hold_q)
  );

  clkdiv3_divn #(.DIV_N(DIV_N), .CNT_W(CNT_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_fall_i (ref_fall),
    .hold_i     (hold_q),
    .div_clk_o  (cpu_clk_o),
    .wrap_o     (wrap),
    .cnt_o      (div_cnt)
  );

  clkdiv3_tgl u_per (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold_q),
    .step_i (wrap),
    .tgl_o  (per_clk_o)
  );
endmodule

// File: rtl/clkdiv3_gen_chk.sv
module clkdiv3_gen_chk #(
  parameter int unsigned DIV_N = 3,
  parameter int unsigned CNT_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_clk_o,
  input logic             per_clk_o,
  input logic             hold,
  input logic             ref_fall,
  input logic [CNT_W-1:0] cnt
);
  // R7: a captured sync level forces both clocks low on the next edge
  p_hold_forces_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> (!cpu_clk_o && !per_clk_o));

  // R3: the count never leaves 0..DIV_N-1
  p_cnt_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < CNT_W'(DIV_N));

  // R5: cpu clock moves only after a reference fall or a hold
  p_clk_on_ref_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cpu_clk_o) |-> $past(ref_fall || hold));

  // R4: the high phase survives until the next reference fall
  p_high_one_ref_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_o && !ref_fall && !hold) |=> cpu_clk_o);

  // R6: peripheral clock changes only together with a cpu clock fall
  p_per_on_cpu_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(per_clk_o) && !$past(hold)) |-> $fell(cpu_clk_o));
endmodule

bind clkdiv3_gen clkdiv3_gen_chk #(.DIV_N(DIV_N), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cpu_clk_o (cpu_clk_o),
  .per_clk_o (per_clk_o),
  .hold      (hold_q),
  .ref_fall  (ref_fall),
  .cnt       (div_cnt)
);

// File: tb/tb_clkdiv3_gen.sv
module tb_clkdiv3_gen;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic xtal_i = 1'b0, ext_ref_i = 1'b0, ext_sel_i = 1'b0, phase_sync_i = 1'b0;
  logic cpu_clk_o, per_clk_o, ref_buf_o;

  int    n_checks = 0, n_err = 0;
  longint cyc = 0;
  int    xtal_h = 5, ext_h = 7;
  longint xtal_fall_cyc = 0, ext_fall_cyc = 0;
  int    ext_falls = 0;

  typedef struct packed {
    bit sel; int xh; int eh; int per; int hi; int pper; int phi;
  } vec_t;
  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5, 7, 30, 10, 60, 30},
    '{1'b1, 9, 7, 42, 14, 84, 42},
    '{1'b0, 8, 5, 48, 16, 96, 48},
    '{1'b1, 6, 4, 24,  8, 48, 24}
  };

  clkdiv3_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .xtal_i(xtal_i), .ext_ref_i(ext_ref_i),
    .ext_sel_i(ext_sel_i), .phase_sync_i(phase_sync_i),
    .cpu_clk_o(cpu_clk_o), .per_clk_o(per_clk_o), .ref_buf_o(ref_buf_o)
  );

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  initial forever begin
    repeat (xtal_h) @(negedge clk_i);
    xtal_i = ~xtal_i;
    if (!xtal_i) xtal_fall_cyc = cyc;
  end

  initial forever begin
    repeat (ext_h) @(negedge clk_i);
    ext_ref_i = ~ext_ref_i;
    if (!ext_ref_i) begin ext_fall_cyc = cyc; ext_falls++; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_edge(input bit use_per, input bit lvl, output longint t);
    bit prev, cur;
    prev = use_per ? per_clk_o : cpu_clk_o;
    forever begin
      @(negedge clk_i);
      cur = use_per ? per_clk_o : cpu_clk_o;
      if (cur == lvl && prev != lvl) break;
      prev = cur;
    end
    t = cyc;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(cpu_clk_o == 1'b0 && per_clk_o == 1'b0, "R1", "clocks in reset",
          {cpu_clk_o, per_clk_o}, 0);
    end
    rst_ni = 1'b1;
  endtask

  function automatic longint last_fall();
    return ext_sel_i ? ext_fall_cyc : xtal_fall_cyc;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    longint t0, t1, t2, p0, p1, p2, base;
    bit bad;
    do_reset();

    // table walk: source select, period and duty cycle
    for (int v = 0; v < NV; v++) begin
      ext_sel_i = VECS[v].sel;
      xtal_h    = VECS[v].xh;
      ext_h     = VECS[v].eh;
      do_reset();
      repeat (10) @(negedge clk_i);
      #1;
      chk(ref_buf_o == (ext_sel_i ? ext_ref_i : xtal_i), "R10", "buffered reference",
          ref_buf_o, ext_sel_i ? ext_ref_i : xtal_i);
      wait_edge(1'b0, 1'b1, t0);
      chk((t0 - last_fall()) >= 2 && (t0 - last_fall()) <= 4, "R5", "rise latency",
          t0 - last_fall(), 3);
      wait_edge(1'b0, 1'b0, t1);
      chk((t1 - last_fall()) >= 2 && (t1 - last_fall()) <= 4, "R5", "fall latency",
          t1 - last_fall(), 3);
      wait_edge(1'b0, 1'b1, t2);
      chk(t2 - t0 == VECS[v].per, "R2 R3", "cpu clock period", t2 - t0, VECS[v].per);
      chk(t1 - t0 == VECS[v].hi, "R4", "cpu clock high time", t1 - t0, VECS[v].hi);
      wait_edge(1'b1, 1'b1, p0);
      wait_edge(1'b1, 1'b0, p1);
      wait_edge(1'b1, 1'b1, p2);
      chk(p2 - p0 == VECS[v].pper, "R6", "peripheral period", p2 - p0, VECS[v].pper);
      chk(p1 - p0 == VECS[v].phi, "R6", "peripheral high time", p1 - p0, VECS[v].phi);
    end

    // reset in the middle of activity
    do_reset();

    // R7: hold while sync is captured high
    ext_sel_i = 1'b1; ext_h = 7; xtal_h = 5;
    do_reset();
    repeat (60) @(negedge clk_i);
    phase_sync_i = 1'b1;
    repeat (3) @(posedge ext_ref_i);
    bad = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      if (cpu_clk_o || per_clk_o) bad = 1'b1;
    end
    chk(!bad, "R7", "clocks held low under sync", bad, 0);

    // R8: release while the external input is low
    @(negedge ext_ref_i);
    repeat (2) @(negedge clk_i);
    phase_sync_i = 1'b0;
    @(posedge ext_ref_i);
    base = ext_falls;
    wait_edge(1'b0, 1'b1, t0);
    chk(ext_falls - base == 2, "R8", "reference falls before first rise",
        ext_falls - base, 2);

    // R9: short pulse between two rising edges of the external input
    wait_edge(1'b0, 1'b1, t0);
    @(negedge ext_ref_i);
    repeat (2) @(negedge clk_i);
    phase_sync_i = 1'b1;
    repeat (2) @(negedge clk_i);
    phase_sync_i = 1'b0;
    wait_edge(1'b0, 1'b1, t1);
    chk(t1 - t0 == 42, "R9", "period across ignored pulse", t1 - t0, 42);

    // R10 in crystal mode with the other input differing
    ext_sel_i = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i); #1;
      if (ref_buf_o != xtal_i) bad = 1'b1;
    end
    chk(ref_buf_o == xtal_i, "R10", "buffer follows crystal", ref_buf_o, xtal_i);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule